// File: doc/BRIEF.md
# Hybrid Circuit/Packet Mesh Router

This block is one node of an on-chip mesh. It has five flit ports: local (0), north (1), south (2), east (3) and west (4). Every input and every output is a valid/ready flit interface. Each output runs in one of two modes. In circuit mode, a configuration entry binds the output to one input. Flits from that input then pass straight through as plain wires, with no buffering, routing or arbitration, so the hop adds no register. In packet mode, flits wait in a small FIFO at each input. They are steered by dimension-order XY routing, and a round-robin arbiter shares each output.

A command interface sets up and tears down circuits. Software or a protocol engine normally sends the first transfer between two nodes in packet mode and then issues a setup. Later transfers between that pair ride the circuit. The number of live circuits is limited. When a setup finds no free slot, the path that carried traffic least recently is reclaimed. A path is never released while a flit is being offered on its input.

Top module: `hcr_router`

## Requirements
- R1: After reset, no output holds a circuit, every `out_valid_o` bit is 0, every `in_ready_o` bit is 1 and `cmd_ready_o` is 1.
- R2: While output o holds a circuit bound to input i, `out_valid_o[o]` and `out_data_o` slice o follow input i in the same cycle, whatever destination the flit carries. `in_ready_o[i]` follows `out_ready_i[o]`, and the flit does not appear on its XY-routed output.
- R3: An accepted setup command (`cmd_tear_i`=0) with input and output indices below 5 makes the circuit active from the cycle after acceptance.
- R4: In packet mode, the flit's destination X is bits [1:0] and destination Y is bits [3:2]. Routing compares them with the node's own position (1,1):
  - X greater selects east (3) and X smaller selects west (4).
  - When X is equal, Y greater selects north (1) and Y smaller selects south (2).
  - When both are equal, the flit goes to local (0).
  - A flit accepted at one clock edge is offered on its output right after that edge, not before.
- R5: A setup whose output, or whose input, already belongs to a live circuit removes that circuit and installs the new one in its place.
- R6: At most MAX_PATHS (default 2) circuits are live at once. A setup with no port conflict, issued while the table is full, evicts the circuit that has gone the longest without being installed or carrying a flit. On a tie, the lowest output index is evicted.
- R7: A teardown (`cmd_tear_i`=1) frees the circuit on `cmd_out_i` from the next cycle. Any command that would remove a circuit waits, with `cmd_ready_o` at 0, while that circuit's input has `in_valid_i` asserted.
- R8: A packet flit routed to an output that holds a circuit waits in its FIFO. It is delivered once the circuit is torn down.
- R9: Packet flits from two inputs contending for the same output are granted in alternation.
- R10: A command naming a port index of 5 or above is accepted and changes no circuit.
- R11: An input FIFO holding FIFO_DEPTH (default 2) flits drives `in_ready_o` for that input low until a flit leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 5 | Flit valid per input port |
| in_ready_o | output | 5 | Flit ready per input port |
| in_data_i | input | 5*DATA_W | Flit per input, port p at bits [p*DATA_W +: DATA_W] |
| out_valid_o | output | 5 | Flit valid per output port |
| out_ready_i | input | 5 | Flit ready per output port |
| out_data_o | output | 5*DATA_W | Flit per output, port p at bits [p*DATA_W +: DATA_W] |
| cmd_valid_i | input | 1 | Path command valid |
| cmd_ready_o | output | 1 | Path command accepted when high with valid |
| cmd_tear_i | input | 1 | 0 = setup, 1 = teardown |
| cmd_in_i | input | 3 | Input port index of the circuit (setup only) |
| cmd_out_i | input | 3 | Output port index of the circuit |

## Verification
Circuit results are combinational. The bench drives a flit on a falling edge and samples the bound output a nanosecond later, before any clock edge. A packet flit takes one register. The bench first checks that the output is still idle in the driving cycle, then checks it again after the accepting edge, and each further queued flit is sampled one falling edge later. A command acts one edge after acceptance, so every command task returns on the falling edge after the accepting edge, and the follow-up check happens there.

// File: rtl/hcr_pkg.sv
`timescale 1ns/1ps
package hcr_pkg;
  localparam int NP = 5;
  localparam int PW = 3;
  typedef enum logic [PW-1:0] {
    P_LOC   = 3'd0,
    P_NORTH = 3'd1,
    P_SOUTH = 3'd2,
    P_EAST  = 3'd3,
    P_WEST  = 3'd4
  } port_e;
endpackage

// File: rtl/hcr_fifo.sv
`timescale 1ns/1ps
module hcr_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= data_i;
  end
endmodule

// File: rtl/hcr_rr_arb.sv
`timescale 1ns/1ps
module hcr_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q, win;
  logic          found;

  always_comb begin
    int idx;
    idx   = 0;
    gnt_o = '0;
    win   = ptr_q;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!found && req_i[idx]) begin
        found      = 1'b1;
        gnt_o[idx] = 1'b1;
        win        = IW'(idx);
      end
    end
  end

  // pointer moves past the winner only when its flit is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i && found) ptr_q <= (int'(win) == N-1) ? '0 : win + 1'b1;
  end
endmodule

// File: rtl/hcr_path_table.sv
`timescale 1ns/1ps
module hcr_path_table #(
  parameter int NP        = 5,
  parameter int PW        = 3,
  parameter int MAX_PATHS = 2,
  parameter int AGE_W     = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic            cmd_tear_i,
  input  logic [PW-1:0]   cmd_in_i,
  input  logic [PW-1:0]   cmd_out_i,
  output logic            cmd_ready_o,
  input  logic [NP-1:0]   in_valid_i,
  input  logic [NP-1:0]   use_i,
  output logic [NP-1:0]   held_o,
  output logic [NP*PW-1:0] src_o
);
  logic [NP-1:0]    vld_q;
  logic [PW-1:0]    src_q [NP];
  logic [AGE_W-1:0] age_q [NP];

  logic             cmd_ok, full, fire, found;
  logic [AGE_W-1:0] best_age;
  logic [NP-1:0]    lru_oh, hit_out, hit_in, busy, kill;

  always_comb begin
    int best_idx;
    best_idx = 0;
    cmd_ok   = (cmd_out_i < PW'(NP)) && (cmd_tear_i || (cmd_in_i < PW'(NP)));
    found    = 1'b0;
    best_age = '0;
    lru_oh   = '0;
    for (int o = 0; o < NP; o++) begin
      if (vld_q[o] && (!found || age_q[o] > best_age)) begin
        found    = 1'b1;
        best_age = age_q[o];
        best_idx = o;
      end
      hit_out[o] = vld_q[o] && (PW'(o) == cmd_out_i);
      hit_in[o]  = vld_q[o] && (src_q[o] == cmd_in_i);
      busy[o]    = vld_q[o] && in_valid_i[src_q[o]];
    end
    if (found) lru_oh[best_idx] = 1'b1;
    full = ($countones(vld_q) >= MAX_PATHS);
    kill = '0;
    if (cmd_ok) begin
      if (cmd_tear_i)              kill = hit_out;
      else if (|(hit_out | hit_in)) kill = hit_out | hit_in;
      else if (full)               kill = lru_oh;
    end
    // never drop a path whose input is offering a flit
    cmd_ready_o = ~|(kill & busy);
    fire        = cmd_valid_i && cmd_ready_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int o = 0; o < NP; o++) begin
        src_q[o] <= '0;
        age_q[o] <= '0;
      end
    end else begin
      for (int o = 0; o < NP; o++) begin
        if (fire && kill[o]) vld_q[o] <= 1'b0;
        if (vld_q[o] && use_i[o])  age_q[o] <= '0;
        else if (age_q[o] != '1)   age_q[o] <= age_q[o] + 1'b1;
        if (fire && cmd_ok && !cmd_tear_i && (PW'(o) == cmd_out_i)) begin
          vld_q[o] <= 1'b1;
          src_q[o] <= cmd_in_i;
          age_q[o] <= '0;
        end
      end
    end
  end

  assign held_o = vld_q;
  for (genvar o = 0; o < NP; o++) begin : g_src
    assign src_o[o*PW +: PW] = src_q[o];
  end
endmodule

// File: rtl/hcr_router.sv
`timescale 1ns/1ps
module hcr_router
  import hcr_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int COORD_W    = 2,
  parameter int MY_X       = 1,
  parameter int MY_Y       = 1,
  parameter int FIFO_DEPTH = 2,
  parameter int MAX_PATHS  = 2,
  parameter int AGE_W      = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NP-1:0]        in_valid_i,
  output logic [NP-1:0]        in_ready_o,
  input  logic [NP*DATA_W-1:0] in_data_i,
  output logic [NP-1:0]        out_valid_o,
  input  logic [NP-1:0]        out_ready_i,
  output logic [NP*DATA_W-1:0] out_data_o,
  input  logic                 cmd_valid_i,
  output logic                 cmd_ready_o,
  input  logic                 cmd_tear_i,
  input  logic [PW-1:0]        cmd_in_i,
  input  logic [PW-1:0]        cmd_out_i
);
  function automatic logic [PW-1:0] xy_route(input logic [2*COORD_W-1:0] d);
    logic [COORD_W-1:0] dx, dy;
    dx = d[COORD_W-1:0];
    dy = d[2*COORD_W-1:COORD_W];
    if (dx > COORD_W'(MY_X))      return PW'(P_EAST);
    else if (dx < COORD_W'(MY_X)) return PW'(P_WEST);
    else if (dy > COORD_W'(MY_Y)) return PW'(P_NORTH);
    else if (dy < COORD_W'(MY_Y)) return PW'(P_SOUTH);
    else                          return PW'(P_LOC);
  endfunction

  logic [DATA_W-1:0]       in_arr [NP];
  logic [DATA_W-1:0]       head   [NP];
  logic [PW-1:0]           src    [NP];
  logic [PW-1:0]           rt     [NP];
  logic [PW-1:0]           bout   [NP];
  logic [NP*PW-1:0]        src_flat;
  logic [NP-1:0]           held, bound, empty, full, push, pop, use_v;
  logic [NP-1:0][NP-1:0]   req, gnt;

  hcr_path_table #(
    .NP(NP), .PW(PW), .MAX_PATHS(MAX_PATHS), .AGE_W(AGE_W)
  ) u_table (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_tear_i, .cmd_in_i, .cmd_out_i, .cmd_ready_o,
    .in_valid_i, .use_i(use_v), .held_o(held), .src_o(src_flat)
  );

  // input side: bound inputs bypass their FIFO
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      bound[i] = 1'b0;
      bout[i]  = '0;
      pop[i]   = 1'b0;
      for (int o = 0; o < NP; o++) begin
        if (held[o] && src[o] == PW'(i)) begin
          bound[i] = 1'b1;
          bout[i]  = PW'(o);
        end
        pop[i] = pop[i] | (gnt[o][i] & out_ready_i[o]);
      end
      in_ready_o[i] = bound[i] ? out_ready_i[bout[i]] : !full[i];
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_in
    assign in_arr[i] = in_data_i[i*DATA_W +: DATA_W];
    assign src[i]    = src_flat[i*PW +: PW];
    assign push[i]   = in_valid_i[i] & ~bound[i] & ~full[i];
    assign rt[i]     = xy_route(head[i][2*COORD_W-1:0]);

    hcr_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i, .rst_ni,
      .push_i(push[i]), .data_i(in_arr[i]),
      .pop_i(pop[i]), .data_o(head[i]),
      .empty_o(empty[i]), .full_o(full[i])
    );
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    logic [DATA_W-1:0] pkt_d;

    for (genvar i = 0; i < NP; i++) begin : g_req
      // a held output accepts no packet traffic
      assign req[o][i] = ~empty[i] & (rt[i] == PW'(o)) & ~held[o];
    end

    hcr_rr_arb #(.N(NP)) u_arb (
      .clk_i, .rst_ni,
      .req_i(req[o]), .adv_i(out_ready_i[o]), .gnt_o(gnt[o])
    );

    always_comb begin
      pkt_d = '0;
      for (int i = 0; i < NP; i++) if (gnt[o][i]) pkt_d = pkt_d | head[i];
    end

    assign out_valid_o[o]                  = held[o] ? in_valid_i[src[o]] : |gnt[o];
    assign out_data_o[o*DATA_W +: DATA_W]  = held[o] ? in_arr[src[o]] : pkt_d;
    assign use_v[o]                        = held[o] & in_valid_i[src[o]] & out_ready_i[o];
  end
endmodule

// File: rtl/hcr_router_chk.sv
`timescale 1ns/1ps
module hcr_router_chk
  import hcr_pkg::*;
#(
  parameter int MAX_PATHS = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NP-1:0]    in_valid_i,
  input logic             cmd_valid_i,
  input logic             cmd_ready_i,
  input logic             cmd_tear_i,
  input logic [PW-1:0]    cmd_in_i,
  input logic [PW-1:0]    cmd_out_i,
  input logic [NP-1:0]    held_i,
  input logic [NP*PW-1:0] src_i
);
  p_path_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(held_i) <= MAX_PATHS);

  for (genvar a = 0; a < NP; a++) begin : g_a
    for (genvar b = a + 1; b < NP; b++) begin : g_b
      p_unique_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(held_i[a] && held_i[b] && src_i[a*PW +: PW] == src_i[b*PW +: PW]));
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_o
    p_setup_installs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && cmd_ready_i && !cmd_tear_i && cmd_in_i < PW'(NP) && cmd_out_i == PW'(o))
      |=> (held_i[o] && src_i[o*PW +: PW] == $past(cmd_in_i)));

    p_teardown_frees_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && cmd_ready_i && cmd_tear_i && cmd_out_i == PW'(o)) |=> !held_i[o]);

    p_quiet_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(held_i[o]) |-> !$past(in_valid_i[src_i[o*PW +: PW]]));
  end
endmodule

bind hcr_router hcr_router_chk #(.MAX_PATHS(MAX_PATHS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .cmd_valid_i(cmd_valid_i), .cmd_ready_i(cmd_ready_o), .cmd_tear_i(cmd_tear_i),
  .cmd_in_i(cmd_in_i), .cmd_out_i(cmd_out_i), .held_i(held), .src_i(src_flat)
);

// File: tb/hcr_router_tb.sv
`timescale 1ns/1ps
module hcr_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  in_valid = '0, in_ready, out_valid, out_ready = 5'h1f;
  logic [79:0] in_data = '0, out_data;
  logic        cmd_valid = 1'b0, cmd_ready, cmd_tear = 1'b0;
  logic [2:0]  cmd_in = '0, cmd_out = '0;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hcr_router u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_tear_i(cmd_tear),
    .cmd_in_i(cmd_in), .cmd_out_i(cmd_out)
  );

  function automatic logic [15:0] fl(int dx, int dy, int tag);
    return {12'(tag), 2'(dy), 2'(dx)};
  endfunction

  function automatic logic [15:0] od(int o);
    return out_data[o*16 +: 16];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drv(int i, logic [15:0] d);
    in_valid[i] = 1'b1;
    in_data[i*16 +: 16] = d;
  endtask

  task automatic push(int i, logic [15:0] d);
    @(negedge clk); drv(i, d);
    @(negedge clk); in_valid[i] = 1'b0;
    #1;
  endtask

  task automatic cmd(bit tear, int src, int dst);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_tear = tear; cmd_in = 3'(src); cmd_out = 3'(dst);
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk); cmd_valid = 1'b0;
    #1;
  endtask

  task automatic clear_all();
    for (int o = 0; o < 5; o++) cmd(1'b1, 0, o);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid == 5'h0, "R1 out_valid", 32'(out_valid), 0);
    chk(in_ready == 5'h1f, "R1 in_ready", 32'(in_ready), 32'h1f);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", 32'(cmd_ready), 1);
  endtask

  task automatic route_case(int dx, int dy, int exp, int tag);
    @(negedge clk); drv(4, fl(dx, dy, tag)); #1;
    chk(out_valid[exp] == 1'b0, "R4 not before edge", 32'(out_valid[exp]), 0);
    @(negedge clk); in_valid[4] = 1'b0; #1;
    chk(out_valid[exp] == 1'b1, "R4 valid after edge", 32'(out_valid[exp]), 1);
    chk(od(exp) == fl(dx, dy, tag), "R4 data", 32'(od(exp)), 32'(fl(dx, dy, tag)));
  endtask

  task automatic t_route_r4();
    route_case(2, 1, 3, 'h11);
    route_case(0, 1, 4, 'h12);
    route_case(1, 2, 1, 'h13);
    route_case(1, 0, 2, 'h14);
    route_case(1, 1, 0, 'h15);
    route_case(3, 0, 3, 'h16);
  endtask

  task automatic t_circuit_r2_r3();
    clear_all();
    cmd(1'b0, 0, 3);
    @(negedge clk); drv(0, fl(1, 1, 'h21)); #1;
    chk(out_valid[3] == 1'b1, "R3 R2 circuit valid same cycle", 32'(out_valid[3]), 1);
    chk(od(3) == fl(1, 1, 'h21), "R2 circuit data", 32'(od(3)), 32'(fl(1, 1, 'h21)));
    chk(out_valid[0] == 1'b0, "R2 not on routed port", 32'(out_valid[0]), 0);
    out_ready[3] = 1'b0; #1;
    chk(in_ready[0] == 1'b0, "R2 backpressure", 32'(in_ready[0]), 0);
    out_ready[3] = 1'b1; #1;
    chk(in_ready[0] == 1'b1, "R2 ready follows", 32'(in_ready[0]), 1);
    @(negedge clk); in_valid[0] = 1'b0;
    repeat (2) @(negedge clk); #1;
    chk(out_valid[0] == 1'b0, "R2 no packet copy", 32'(out_valid[0]), 0);
  endtask

  task automatic t_teardown_r7();
    clear_all();
    cmd(1'b0, 0, 3);
    @(negedge clk);
    drv(0, fl(1, 1, 'h31)); out_ready[3] = 1'b0;
    cmd_valid = 1'b1; cmd_tear = 1'b1; cmd_out = 3'd3; #1;
    chk(cmd_ready == 1'b0, "R7 teardown held off", 32'(cmd_ready), 0);
    @(negedge clk); #1;
    chk(cmd_ready == 1'b0, "R7 still held off", 32'(cmd_ready), 0);
    chk(out_valid[3] == 1'b1, "R7 path intact", 32'(out_valid[3]), 1);
    in_valid[0] = 1'b0; #1;
    chk(cmd_ready == 1'b1, "R7 released when idle", 32'(cmd_ready), 1);
    @(negedge clk); cmd_valid = 1'b0; out_ready[3] = 1'b1;
    @(negedge clk); drv(0, fl(1, 1, 'h32)); #1;
    chk(out_valid[3] == 1'b0, "R7 circuit gone", 32'(out_valid[3]), 0);
    @(negedge clk); in_valid[0] = 1'b0; #1;
    chk(out_valid[0] == 1'b1 && od(0) == fl(1, 1, 'h32), "R7 packet route after teardown",
        32'(od(0)), 32'(fl(1, 1, 'h32)));
  endtask

  task automatic t_wait_r8();
    clear_all();
    cmd(1'b0, 1, 3);
    push(0, fl(2, 1, 'h41));
    chk(out_valid[3] == 1'b0, "R8 packet blocked", 32'(out_valid[3]), 0);
    repeat (3) @(negedge clk); #1;
    chk(out_valid[3] == 1'b0, "R8 still blocked", 32'(out_valid[3]), 0);
    cmd(1'b1, 0, 3);
    chk(out_valid[3] == 1'b1 && od(3) == fl(2, 1, 'h41), "R8 delivered after teardown",
        32'(od(3)), 32'(fl(2, 1, 'h41)));
    @(negedge clk);
  endtask

  task automatic t_lru_r6();
    // no traffic: oldest (L->E) is evicted
    clear_all();
    cmd(1'b0, 0, 3);
    cmd(1'b0, 1, 2);
    cmd(1'b0, 4, 0);
    @(negedge clk);
    drv(0, fl(1, 2, 'h51)); drv(1, fl(2, 1, 'h52)); drv(4, fl(1, 1, 'h53)); #1;
    chk(out_valid[3] == 1'b0, "R6 oldest evicted", 32'(out_valid[3]), 0);
    chk(out_valid[2] == 1'b1 && od(2) == fl(2, 1, 'h52), "R6 newer kept", 32'(od(2)), 32'(fl(2, 1, 'h52)));
    chk(out_valid[0] == 1'b1 && od(0) == fl(1, 1, 'h53), "R6 new path live", 32'(od(0)), 32'(fl(1, 1, 'h53)));
    @(negedge clk); in_valid = '0;
    repeat (3) @(negedge clk);
    // L->E carries a flit, so N->S becomes least recently used
    clear_all();
    cmd(1'b0, 0, 3);
    cmd(1'b0, 1, 2);
    @(negedge clk); drv(0, fl(1, 1, 'h54));
    @(negedge clk); in_valid[0] = 1'b0;
    cmd(1'b0, 4, 0);
    @(negedge clk);
    drv(0, fl(1, 1, 'h55)); drv(1, fl(1, 0, 'h56)); drv(4, fl(1, 1, 'h57)); #1;
    chk(out_valid[3] == 1'b1 && od(3) == fl(1, 1, 'h55), "R6 used path kept", 32'(od(3)), 32'(fl(1, 1, 'h55)));
    chk(out_valid[2] == 1'b0, "R6 idle path evicted", 32'(out_valid[2]), 0);
    chk(out_valid[0] == 1'b1, "R6 new path live", 32'(out_valid[0]), 1);
    @(negedge clk); in_valid = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_conflict_r5();
    clear_all();
    cmd(1'b0, 0, 3);
    cmd(1'b0, 0, 1);
    @(negedge clk); drv(0, fl(1, 1, 'h61)); #1;
    chk(out_valid[1] == 1'b1 && od(1) == fl(1, 1, 'h61), "R5 input conflict rebinds", 32'(od(1)), 32'(fl(1, 1, 'h61)));
    chk(out_valid[3] == 1'b0, "R5 old output freed", 32'(out_valid[3]), 0);
    @(negedge clk); in_valid[0] = 1'b0;
    cmd(1'b0, 4, 1);
    @(negedge clk); drv(0, fl(1, 1, 'h62)); drv(4, fl(1, 1, 'h63)); #1;
    chk(out_valid[1] == 1'b1 && od(1) == fl(1, 1, 'h63), "R5 output conflict rebinds", 32'(od(1)), 32'(fl(1, 1, 'h63)));
    @(negedge clk); in_valid = '0; #1;
    chk(out_valid[0] == 1'b1 && od(0) == fl(1, 1, 'h62), "R5 old input back to packet", 32'(od(0)), 32'(fl(1, 1, 'h62)));
    repeat (3) @(negedge clk);
  endtask

  task automatic t_rr_r9();
    logic [15:0] got [4];
    int n;
    clear_all();
    n = 0;
    @(negedge clk); drv(1, fl(2, 1, 'h100)); drv(2, fl(2, 1, 'h200));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) begin drv(1, fl(2, 1, 'h101)); drv(2, fl(2, 1, 'h201)); end
      if (k == 1) in_valid = '0;
      #1;
      if (out_valid[3]) begin got[n] = od(3); n++; end
    end
    chk(n == 4, "R9 all four delivered", 32'(n), 4);
    for (int k = 0; k < 3; k++)
      chk(got[k][15:12] != got[k+1][15:12], "R9 alternation", 32'(got[k+1][15:12]), 32'(got[k][15:12]));
  endtask

  task automatic t_badport_r10();
    clear_all();
    cmd(1'b0, 0, 1);
    @(negedge clk); cmd_valid = 1'b1; cmd_tear = 1'b0; cmd_in = 3'd5; cmd_out = 3'd3; #1;
    chk(cmd_ready == 1'b1, "R10 bad setup accepted", 32'(cmd_ready), 1);
    @(negedge clk); cmd_tear = 1'b1; cmd_out = 3'd7; #1;
    chk(cmd_ready == 1'b1, "R10 bad teardown accepted", 32'(cmd_ready), 1);
    @(negedge clk); cmd_valid = 1'b0;
    drv(0, fl(2, 1, 'h71)); #1;
    chk(out_valid[1] == 1'b1 && od(1) == fl(2, 1, 'h71), "R10 path unchanged", 32'(od(1)), 32'(fl(2, 1, 'h71)));
    chk(out_valid[3] == 1'b0, "R10 no circuit on east", 32'(out_valid[3]), 0);
    @(negedge clk); in_valid[0] = 1'b0;
    push(2, fl(2, 1, 'h72));
    chk(out_valid[3] == 1'b1 && od(3) == fl(2, 1, 'h72), "R10 east stays packet", 32'(od(3)), 32'(fl(2, 1, 'h72)));
    @(negedge clk);
  endtask

  task automatic t_full_r11();
    clear_all();
    out_ready[3] = 1'b0;
    push(0, fl(2, 1, 'h81));
    chk(in_ready[0] == 1'b1, "R11 room after one", 32'(in_ready[0]), 1);
    push(0, fl(2, 1, 'h82));
    chk(in_ready[0] == 1'b0, "R11 full drops ready", 32'(in_ready[0]), 0);
    chk(od(3) == fl(2, 1, 'h81), "R11 head held", 32'(od(3)), 32'(fl(2, 1, 'h81)));
    out_ready[3] = 1'b1;
    @(negedge clk); #1;
    chk(out_valid[3] == 1'b1 && od(3) == fl(2, 1, 'h82), "R11 second in order", 32'(od(3)), 32'(fl(2, 1, 'h82)));
    chk(in_ready[0] == 1'b1, "R11 ready back", 32'(in_ready[0]), 1);
    @(negedge clk); #1;
    chk(out_valid[3] == 1'b0, "R11 drained", 32'(out_valid[3]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_route_r4();
    t_circuit_r2_r3();
    t_teardown_r7();
    t_wait_r8();
    t_lru_r6();
    t_conflict_r5();
    t_rr_r9();
    t_badport_r10();
    t_full_r11();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule